// File: doc/BRIEF.md
# Interrupt Pin Request and Redelivery Controller

This block holds the request state for a bank of interrupt input pins and decides when each pin asks for delivery toward the local interrupt controllers. Line events arrive one per cycle as a pin number with a new level. Each pin has a mask bit, a trigger mode (edge or level) and a vector. These are supplied from outside as flat configuration buses. Destination decoding and the message fabric lie outside the block. It offers one delivery request at a time on a valid/done handshake. The far side reports whether at least one target accepted it.

Level-triggered pins hold a remote-IRR flag from an accepted delivery until an end-of-interrupt (EOI) naming their vector arrives. When remote-IRR is cleared, a pin that is still asserted and unmasked is redelivered at once. A per-pin storm counter limits this. When back-to-back redeliveries reach a limit, the pin waits for a deferred sweep that starts after a programmable number of cycles. When a pin becomes due, it is marked pending. Pending pins are served lowest index first.

Top module: `pin_dlv_ctrl`

## Requirements
- R1: After reset no delivery is offered, and every request bit and every remote-IRR bit reads 0.
- R2: A line event with level 0 clears that pin's request bit, and the pin is not delivered.
- R3: A level-1 event on an edge pin (cfg_level bit 0) whose request bit is already 1 raises req_coalesced for exactly the cycle after the event and starts no delivery. If the request bit was 0, the bit is set and the pin is delivered: dlv_valid is seen one cycle after the event.
- R4: A pin whose cfg_mask bit is 1 is never offered. A level pin (cfg_level bit 1) with remote-IRR set is never offered. A request on such a pin only sets its request bit.
- R5: A delivery presents the pin number, that pin's vector and its trigger mode. These hold steady with dlv_valid until dlv_done. Only one delivery is outstanding at a time. When several pins are pending, the lowest pin index is served first.
- R6: A completed delivery of a level pin with dlv_accepted=1 sets that pin's remote-IRR. It stays clear when dlv_accepted=0, and it is never set for an edge pin.
- R7: An EOI clears remote-IRR on every level pin whose vector equals eoi_vector. It has no effect when eoi_suppress is 1, and none on pins with a different vector.
- R8: When an EOI clears remote-IRR on an unmasked pin whose request bit is 1, the pin is redelivered with dlv_valid one cycle after the EOI, and its storm count increases by one. In every other case the EOI sets the count to 0, and when the request bit is 0 no delivery follows.
- R9: The STORM_LIMIT-th redelivery in a row is skipped and the count returns to 0. A sweep then delivers every unmasked level pin with its request bit 1 and remote-IRR clear, with dlv_valid appearing DEFER_CYCLES+1 cycles after that EOI.
- R10: When a level pin's mask falls while its request bit is 1 and remote-IRR is clear, the pin is delivered one cycle later. If its cfg_resample bit is 1, the request bit is cleared instead and no delivery follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mask | input | NPINS | Per-pin mask, 1 = masked |
| cfg_level | input | NPINS | Per-pin trigger mode, 1 = level, 0 = edge |
| cfg_vector | input | NPINS*VECW | Per-pin vector, pin i at bits i*VECW upward |
| cfg_resample | input | NPINS | Per-pin flag: drop a stale request on unmask instead of delivering it |
| req_valid | input | 1 | A line event is present |
| req_pin | input | PINW | Pin number of the line event |
| req_level | input | 1 | New line level of the event |
| req_coalesced | output | 1 | Pulse: the previous event was merged into an already set request |
| eoi_valid | input | 1 | End-of-interrupt broadcast present |
| eoi_vector | input | VECW | Vector named by the EOI |
| eoi_suppress | input | 1 | EOI broadcast suppression, EOI leaves remote-IRR alone |
| dlv_valid | output | 1 | Delivery request outstanding |
| dlv_pin | output | PINW | Pin being delivered |
| dlv_vector | output | VECW | Vector of the pin being delivered |
| dlv_level | output | 1 | Trigger mode of the pin being delivered |
| dlv_done | input | 1 | Delivery finished this cycle |
| dlv_accepted | input | 1 | With dlv_done: at least one target took the interrupt |
| irr_o | output | NPINS | Request bits |
| rirr_o | output | NPINS | Remote-IRR bits |

## Verification
The bench builds the block with four pins: two edge and two level, each with its own vector. It uses a storm limit of 3 and a sweep delay of 20 cycles. With these values a full run of redeliveries up to the skipped one, the deferred sweep and the reset of the count all happen within a few dozen cycles. With only four pins, every trigger mode, the mask, the resample option and the ascending service order can each be driven on a known pin. The latencies of direct redelivery (1) and of deferred redelivery (21) are computed in the bench from the parameters.

// File: rtl/pdc_pkg.sv
package pdc_pkg;

  // Index of the lowest set bit; 0 when no bit is set.
  function automatic logic [5:0] lowest_index(input logic [63:0] v);
    logic [5:0] r;
    r = '0;
    for (int i = 63; i >= 0; i--) begin
      if (v[i]) r = 6'(i);
    end
    return r;
  endfunction

  // True when one more back-to-back redelivery would reach the limit.
  function automatic logic storm_reached(input logic [31:0] cnt,
                                         input logic [31:0] limit);
    return (cnt + 32'd1) >= limit;
  endfunction

endpackage

// File: rtl/pdc_pin.sv
module pdc_pin #(
  parameter int VECW  = 8,
  parameter int LIMIT = 10000,
  parameter int CNTW  = 14
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_mask,
  input  logic            cfg_level,
  input  logic [VECW-1:0] cfg_vec,
  input  logic            cfg_resample,
  input  logic            set_hit,
  input  logic            set_level,
  input  logic            eoi_valid,
  input  logic [VECW-1:0] eoi_vector,
  input  logic            eoi_suppress,
  input  logic            scan,
  input  logic            taken,
  input  logic            acc_done,
  output logic            irr,
  output logic            rirr,
  output logic            pend,
  output logic            storm,
  output logic            coal
);
  logic irr_q, rirr_q, pend_q, mask_q;
  logic [CNTW-1:0] cnt_q;

  // named events
  logic unmask_ev, eoi_do, rise_ev, unm_live, resample_drop, unm_req;
  logic redo_ok, eoi_req, scan_req, any_req, blocked_n, rirr_n;

  assign unmask_ev     = mask_q & ~cfg_mask;
  assign eoi_do        = eoi_valid & (eoi_vector == cfg_vec) & cfg_level & ~eoi_suppress;
  assign rise_ev       = set_hit & set_level;
  assign coal          = rise_ev & ~cfg_level & irr_q;
  assign unm_live      = unmask_ev & cfg_level & irr_q & ~rirr_q;
  assign resample_drop = unm_live & cfg_resample;
  assign unm_req       = unm_live & ~cfg_resample;
  assign redo_ok       = eoi_do & ~cfg_mask & irr_q;
  assign storm         = redo_ok & pdc_pkg::storm_reached(32'(cnt_q), LIMIT);
  assign eoi_req       = redo_ok & ~storm;
  assign scan_req      = scan & cfg_level & irr_q & ~rirr_q;
  assign any_req       = (rise_ev & ~coal) | unm_req | eoi_req | scan_req;
  assign rirr_n        = (rirr_q | acc_done) & ~eoi_do;
  assign blocked_n     = cfg_mask | (cfg_level & rirr_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr_q  <= 1'b0;
      rirr_q <= 1'b0;
      pend_q <= 1'b0;
      mask_q <= 1'b1;
      cnt_q  <= '0;
    end else begin
      mask_q <= cfg_mask;
      rirr_q <= rirr_n;
      pend_q <= ((pend_q & ~taken) | any_req) & ~blocked_n;
      if (set_hit)            irr_q <= set_level;
      else if (resample_drop) irr_q <= 1'b0;
      if (eoi_do) begin
        if (redo_ok && !storm) cnt_q <= cnt_q + 1'b1;
        else                   cnt_q <= '0;
      end
    end
  end

  assign irr  = irr_q;
  assign rirr = rirr_q;
  assign pend = pend_q;
endmodule

// File: rtl/pdc_arb.sv
module pdc_arb #(
  parameter int NPINS = 24,
  parameter int VECW  = 8,
  parameter int PINW  = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NPINS-1:0]      elig,
  input  logic [NPINS-1:0]      cfg_level,
  input  logic [NPINS*VECW-1:0] cfg_vector,
  input  logic                  dlv_done,
  input  logic                  dlv_accepted,
  output logic [NPINS-1:0]      taken,
  output logic                  busy,
  output logic [PINW-1:0]       pin,
  output logic [VECW-1:0]       vec,
  output logic                  lvl,
  output logic [NPINS-1:0]      acc_done
);
  localparam logic [NPINS-1:0] ONE = NPINS'(1);

  logic            busy_q, lvl_q, pick;
  logic [PINW-1:0] pin_q;
  logic [VECW-1:0] vec_q;
  logic [5:0]      first;

  assign first = pdc_pkg::lowest_index(64'(elig));
  assign pick  = !busy_q && (|elig);
  assign taken = pick ? (ONE << first) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      lvl_q  <= 1'b0;
      pin_q  <= '0;
      vec_q  <= '0;
    end else if (pick) begin
      busy_q <= 1'b1;
      pin_q  <= PINW'(first);
      vec_q  <= cfg_vector[int'(first)*VECW +: VECW];
      lvl_q  <= cfg_level[first];
    end else if (busy_q && dlv_done) begin
      busy_q <= 1'b0;
    end
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_acc
    assign acc_done[i] = busy_q & dlv_done & dlv_accepted & lvl_q & (pin_q == PINW'(i));
  end

  assign busy = busy_q;
  assign pin  = pin_q;
  assign vec  = vec_q;
  assign lvl  = lvl_q;
endmodule

// File: rtl/pdc_defer.sv
module pdc_defer #(
  parameter int CYC = 1000000,
  parameter int W   = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  output logic fire
);
  logic         run_q;
  logic [W-1:0] cnt_q;

  assign fire = run_q && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (arm && (!run_q || fire)) begin
      run_q <= 1'b1;
      cnt_q <= W'(CYC - 1);
    end else if (run_q) begin
      if (fire) run_q <= 1'b0;
      else      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/pin_dlv_ctrl.sv
module pin_dlv_ctrl #(
  parameter int NPINS        = 24,
  parameter int VECW         = 8,
  parameter int STORM_LIMIT  = 10000,
  parameter int DEFER_CYCLES = 1000000,
  parameter int PINW         = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NPINS-1:0]      cfg_mask,
  input  logic [NPINS-1:0]      cfg_level,
  input  logic [NPINS*VECW-1:0] cfg_vector,
  input  logic [NPINS-1:0]      cfg_resample,
  input  logic                  req_valid,
  input  logic [PINW-1:0]       req_pin,
  input  logic                  req_level,
  output logic                  req_coalesced,
  input  logic                  eoi_valid,
  input  logic [VECW-1:0]       eoi_vector,
  input  logic                  eoi_suppress,
  output logic                  dlv_valid,
  output logic [PINW-1:0]       dlv_pin,
  output logic [VECW-1:0]       dlv_vector,
  output logic                  dlv_level,
  input  logic                  dlv_done,
  input  logic                  dlv_accepted,
  output logic [NPINS-1:0]      irr_o,
  output logic [NPINS-1:0]      rirr_o
);
  localparam int CNTW = $clog2(STORM_LIMIT + 1);
  localparam int DEFW = $clog2(DEFER_CYCLES + 1);

  logic [NPINS-1:0] pend_vec, storm_vec, coal_vec, take_vec, acc_vec, elig_vec;
  logic             defer_fire, coal_q;

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    pdc_pin #(.VECW(VECW), .LIMIT(STORM_LIMIT), .CNTW(CNTW)) u_pin (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_mask    (cfg_mask[i]),
      .cfg_level   (cfg_level[i]),
      .cfg_vec     (cfg_vector[i*VECW +: VECW]),
      .cfg_resample(cfg_resample[i]),
      .set_hit     (req_valid && (req_pin == PINW'(i))),
      .set_level   (req_level),
      .eoi_valid   (eoi_valid),
      .eoi_vector  (eoi_vector),
      .eoi_suppress(eoi_suppress),
      .scan        (defer_fire),
      .taken       (take_vec[i]),
      .acc_done    (acc_vec[i]),
      .irr         (irr_o[i]),
      .rirr        (rirr_o[i]),
      .pend        (pend_vec[i]),
      .storm       (storm_vec[i]),
      .coal        (coal_vec[i])
    );
  end

  assign elig_vec = pend_vec & ~(cfg_mask | (cfg_level & rirr_o));

  pdc_arb #(.NPINS(NPINS), .VECW(VECW), .PINW(PINW)) u_arb (
    .clk         (clk),
    .rst_n       (rst_n),
    .elig        (elig_vec),
    .cfg_level   (cfg_level),
    .cfg_vector  (cfg_vector),
    .dlv_done    (dlv_done),
    .dlv_accepted(dlv_accepted),
    .taken       (take_vec),
    .busy        (dlv_valid),
    .pin         (dlv_pin),
    .vec         (dlv_vector),
    .lvl         (dlv_level),
    .acc_done    (acc_vec)
  );

  pdc_defer #(.CYC(DEFER_CYCLES), .W(DEFW)) u_defer (
    .clk  (clk),
    .rst_n(rst_n),
    .arm  (|storm_vec),
    .fire (defer_fire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) coal_q <= 1'b0;
    else        coal_q <= |coal_vec;
  end
  assign req_coalesced = coal_q;
endmodule

// File: rtl/pin_dlv_ctrl_chk.sv
module pin_dlv_ctrl_chk #(
  parameter int NPINS = 24,
  parameter int VECW  = 8,
  parameter int PINW  = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPINS-1:0] cfg_mask,
  input logic [NPINS-1:0] cfg_level,
  input logic [NPINS-1:0] irr_o,
  input logic [NPINS-1:0] rirr_o,
  input logic             dlv_valid,
  input logic             dlv_done,
  input logic             dlv_accepted,
  input logic             dlv_level,
  input logic [PINW-1:0]  dlv_pin,
  input logic [VECW-1:0]  dlv_vector,
  input logic             eoi_valid,
  input logic             req_valid,
  input logic             req_level,
  input logic [PINW-1:0]  req_pin,
  input logic             req_coalesced,
  input logic [NPINS-1:0] take_vec
);
  logic [NPINS-1:0] mask_prev, lvl_prev, rirr_prev;
  logic [PINW-1:0]  dpin_q, rpin_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_prev <= '1;
      lvl_prev  <= '0;
      rirr_prev <= '0;
      dpin_q    <= '0;
      rpin_q    <= '0;
    end else begin
      mask_prev <= cfg_mask;
      lvl_prev  <= cfg_level;
      rirr_prev <= rirr_o;
      dpin_q    <= dlv_pin;
      rpin_q    <= req_pin;
    end
  end

  p_one_take_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(take_vec));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid && !dlv_done |=> dlv_valid && $stable(dlv_pin) &&
                               $stable(dlv_vector) && $stable(dlv_level));

  p_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dlv_valid) |-> !mask_prev[dlv_pin] && !(lvl_prev[dlv_pin] && rirr_prev[dlv_pin]));

  p_rirr_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid && dlv_done && dlv_accepted && dlv_level && !eoi_valid |=> rirr_o[dpin_q]);

  p_fall_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_level |=> !irr_o[rpin_q]);

  p_coal_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_coalesced |-> $past(req_valid && req_level));
endmodule

bind pin_dlv_ctrl pin_dlv_ctrl_chk #(.NPINS(NPINS), .VECW(VECW), .PINW(PINW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_mask     (cfg_mask),
  .cfg_level    (cfg_level),
  .irr_o        (irr_o),
  .rirr_o       (rirr_o),
  .dlv_valid    (dlv_valid),
  .dlv_done     (dlv_done),
  .dlv_accepted (dlv_accepted),
  .dlv_level    (dlv_level),
  .dlv_pin      (dlv_pin),
  .dlv_vector   (dlv_vector),
  .eoi_valid    (eoi_valid),
  .req_valid    (req_valid),
  .req_level    (req_level),
  .req_pin      (req_pin),
  .req_coalesced(req_coalesced),
  .take_vec     (take_vec)
);

// File: tb/pin_dlv_ctrl_test.sv
module pin_dlv_ctrl_test;
  localparam int N   = 4;
  localparam int VW  = 8;
  localparam int LIM = 3;
  localparam int DEF = 20;
  localparam int PW  = 2;

  logic          clk, rst_n;
  logic [N-1:0]  cfg_mask, cfg_level, cfg_resample;
  logic [N*VW-1:0] cfg_vector;
  logic          req_valid, req_level, req_coalesced;
  logic [PW-1:0] req_pin;
  logic          eoi_valid, eoi_suppress;
  logic [VW-1:0] eoi_vector;
  logic          dlv_valid, dlv_level, dlv_done, dlv_accepted;
  logic [PW-1:0] dlv_pin;
  logic [VW-1:0] dlv_vector;
  logic [N-1:0]  irr_o, rirr_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  bit last_coal;
  int lat;

  pin_dlv_ctrl #(.NPINS(N), .VECW(VW), .STORM_LIMIT(LIM), .DEFER_CYCLES(DEF)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_mask(cfg_mask), .cfg_level(cfg_level),
    .cfg_vector(cfg_vector), .cfg_resample(cfg_resample),
    .req_valid(req_valid), .req_pin(req_pin), .req_level(req_level),
    .req_coalesced(req_coalesced), .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
    .eoi_suppress(eoi_suppress), .dlv_valid(dlv_valid), .dlv_pin(dlv_pin),
    .dlv_vector(dlv_vector), .dlv_level(dlv_level), .dlv_done(dlv_done),
    .dlv_accepted(dlv_accepted), .irr_o(irr_o), .rirr_o(rirr_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int vec_of(int p);
    return 'h30 + p;
  endfunction

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic pulse_req(int p, bit lvl);
    req_valid = 1'b1; req_pin = PW'(p); req_level = lvl;
    step();
    last_coal = req_coalesced;
    req_valid = 1'b0;
  endtask

  task automatic eoi(int v, bit sup);
    eoi_valid = 1'b1; eoi_vector = VW'(v); eoi_suppress = sup;
    step();
    eoi_valid = 1'b0; eoi_suppress = 1'b0;
  endtask

  task automatic wait_dlv(int maxn, output int l);
    l = -1;
    for (int k = 1; k <= maxn; k++) begin
      step();
      if (dlv_valid) begin
        l = k;
        break;
      end
    end
  endtask

  task automatic respond(bit acc);
    dlv_done = 1'b1; dlv_accepted = acc;
    step();
    dlv_done = 1'b0; dlv_accepted = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    cfg_mask = '1; cfg_level = 4'b0110; cfg_resample = '0;
    for (int i = 0; i < N; i++) cfg_vector[i*VW +: VW] = VW'(vec_of(i));
    req_valid = 0; req_pin = '0; req_level = 0;
    eoi_valid = 0; eoi_vector = '0; eoi_suppress = 0;
    dlv_done = 0; dlv_accepted = 0;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R1 reset state
    chk("R1 dlv_valid", int'(dlv_valid), 0);
    chk("R1 irr", int'(irr_o), 0);
    chk("R1 rirr", int'(rirr_o), 0);
    cfg_mask = 4'b1000;
    step();
    wait_dlv(4, lat);
    chk("R1 idle no delivery", lat, -1);

    // R3 edge pin 0 first assertion delivers
    pulse_req(0, 1);
    chk("R3 no coalesce on fresh edge", int'(last_coal), 0);
    wait_dlv(5, lat);
    chk("R3 edge latency", lat, 1);
    chk("R5 pin", int'(dlv_pin), 0);
    chk("R5 vector", int'(dlv_vector), vec_of(0));
    chk("R5 trigger", int'(dlv_level), 0);
    repeat (3) step();
    chk("R5 valid held", int'(dlv_valid), 1);
    chk("R5 vector held", int'(dlv_vector), vec_of(0));
    respond(1);
    chk("R6 edge no rirr", int'(rirr_o[0]), 0);
    chk("R3 irr kept", int'(irr_o[0]), 1);

    // R3 second assertion coalesces
    pulse_req(0, 1);
    chk("R3 coalesced pulse", int'(last_coal), 1);
    wait_dlv(5, lat);
    chk("R3 coalesced no delivery", lat, -1);

    // R2 fall clears
    pulse_req(0, 0);
    chk("R2 irr cleared", int'(irr_o[0]), 0);
    wait_dlv(5, lat);
    chk("R2 no delivery", lat, -1);
    pulse_req(0, 1);
    chk("R3 fresh after fall", int'(last_coal), 0);
    wait_dlv(5, lat);
    chk("R3 redelivery after fall", lat, 1);
    respond(1);

    // R4 masked pin
    pulse_req(3, 1);
    chk("R4 masked irr set", int'(irr_o[3]), 1);
    wait_dlv(5, lat);
    chk("R4 masked no delivery", lat, -1);

    // R6 level pin 1, no target then accepted
    pulse_req(1, 1);
    wait_dlv(5, lat);
    chk("R5 level latency", lat, 1);
    chk("R5 level pin", int'(dlv_pin), 1);
    chk("R5 level vector", int'(dlv_vector), vec_of(1));
    chk("R5 level trigger", int'(dlv_level), 1);
    respond(0);
    chk("R6 no target keeps rirr clear", int'(rirr_o[1]), 0);
    pulse_req(1, 1);
    wait_dlv(5, lat);
    chk("R6 retry delivered", lat, 1);
    respond(1);
    chk("R6 accepted sets rirr", int'(rirr_o[1]), 1);
    pulse_req(1, 1);
    wait_dlv(5, lat);
    chk("R4 rirr blocks", lat, -1);

    // R7 suppression and mismatch
    eoi(vec_of(1), 1);
    chk("R7 suppressed keeps rirr", int'(rirr_o[1]), 1);
    wait_dlv(5, lat);
    chk("R7 suppressed no delivery", lat, -1);
    eoi('h3F, 0);
    chk("R7 other vector keeps rirr", int'(rirr_o[1]), 1);
    wait_dlv(5, lat);
    chk("R7 other vector no delivery", lat, -1);

    // R8 / R9 redelivery and storm
    eoi(vec_of(1), 0);
    chk("R7 matching EOI clears rirr", int'(rirr_o[1]), 0);
    wait_dlv(5, lat);
    chk("R8 redelivery 1", lat, 1);
    respond(1);
    eoi(vec_of(1), 0);
    wait_dlv(5, lat);
    chk("R8 redelivery 2", lat, 1);
    respond(1);
    eoi(vec_of(1), 0);
    wait_dlv(DEF + 5, lat);
    chk("R9 deferred latency", lat, DEF + 1);
    chk("R9 deferred pin", int'(dlv_pin), 1);
    respond(1);
    eoi(vec_of(1), 0);
    wait_dlv(5, lat);
    chk("R9 count zeroed after storm", lat, 1);
    respond(1);

    // R8 count reset when request gone
    pulse_req(1, 0);
    chk("R2 level irr cleared", int'(irr_o[1]), 0);
    eoi(vec_of(1), 0);
    chk("R8 rirr cleared without request", int'(rirr_o[1]), 0);
    wait_dlv(5, lat);
    chk("R8 no redelivery without request", lat, -1);
    pulse_req(1, 1);
    wait_dlv(5, lat);
    chk("R8 level again", lat, 1);
    respond(1);
    eoi(vec_of(1), 0);
    wait_dlv(5, lat);
    chk("R8 after reset first", lat, 1);
    respond(1);
    eoi(vec_of(1), 0);
    wait_dlv(5, lat);
    chk("R8 after reset second direct", lat, 1);
    respond(1);
    pulse_req(1, 0);
    eoi(vec_of(1), 0);

    // R5 ascending order via R10 unmask
    cfg_mask = 4'b1110;
    step();
    pulse_req(1, 1);
    pulse_req(2, 1);
    wait_dlv(3, lat);
    chk("R4 masked level pins wait", lat, -1);
    chk("R4 requests recorded", int'(irr_o[2:1]), 3);
    cfg_mask = 4'b1000;
    step();
    wait_dlv(5, lat);
    chk("R10 unmask delivers", lat, 1);
    chk("R5 lowest first", int'(dlv_pin), 1);
    respond(1);
    wait_dlv(5, lat);
    chk("R5 next pin latency", lat, 1);
    chk("R5 next pin", int'(dlv_pin), 2);
    chk("R5 next vector", int'(dlv_vector), vec_of(2));
    respond(1);

    // R10 resample drop
    cfg_mask = 4'b1100;
    step();
    eoi(vec_of(2), 0);
    chk("R7 pin2 rirr cleared", int'(rirr_o[2]), 0);
    wait_dlv(5, lat);
    chk("R4 masked no redelivery", lat, -1);
    cfg_resample = 4'b0100;
    cfg_mask = 4'b1000;
    step();
    chk("R10 resample clears irr", int'(irr_o[2]), 0);
    wait_dlv(5, lat);
    chk("R10 resample no delivery", lat, -1);

    // R10 unmask without resample
    cfg_mask = 4'b1010;
    step();
    eoi(vec_of(1), 0);
    wait_dlv(3, lat);
    chk("R4 masked after EOI", lat, -1);
    cfg_mask = 4'b1000;
    step();
    wait_dlv(5, lat);
    chk("R10 unmask pending level", lat, 1);
    chk("R10 unmask pin", int'(dlv_pin), 1);
    respond(1);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule